// File: doc/BRIEF.md
# Panel Clock Generator with Bias Output

This block turns a fast reference clock into the clock that drives a display panel. The ratio is set by a small divisor field: the panel clock runs at the fast rate divided by the divisor plus two. Each line strobe from the line timing logic starts a burst of panel clock periods whose length comes from a clocks-per-line field, stored as the count minus one. Alongside the panel clock the block gives downstream logic a one-fast-cycle launch strobe at the edge where pixel data should change. That logic can then run on the fast clock with a clock enable rather than on a derived clock. A bypass input skips the divider and runs the panel at the full fast rate, which suits active-matrix panels.

The same block drives a dual-purpose bias pin. On passive-matrix panels the pin is an AC bias square wave that flips after a programmed number of line strobes. On active-matrix panels the bias count is ignored and the pin carries the data-enable input with a selectable polarity.

The divider is a three-state machine. In `PH_IDLE` no burst is running. `PH_IDLE -> PH_HIGH` occurs when periods are owed and bypass is off. `PH_HIGH -> PH_LOW` occurs when the high-phase count expires. `PH_LOW -> PH_HIGH` is the wrap to the next period when more periods are owed. `PH_LOW -> PH_IDLE` ends the burst.

Top module: `pnl_clkgen`

## Requirements
- R1: While reset is asserted and afterwards until the first line strobe, `pclk_o` and `launch_o` are 0; with `tft_i`=0, `bias_o` is 0.
- R2: A line strobe sampled at fast edge k starts a burst of `cpl_i`+1 panel clock periods. In divided mode `pclk_o` first goes high after edge k+1, and it stays low once the burst ends.
- R3: In divided mode one panel period lasts N = `div_i`+2 fast cycles. The high phase lasts floor(N/2) cycles and the low phase lasts the remaining cycles.
- R4: In divided mode `launch_o` is high for exactly one fast cycle per period. With `inv_clk_i`=0 this is the first cycle of the high phase. With `inv_clk_i`=1 it is the first cycle of the low phase.
- R5: The divisor is sampled only when a period begins. A change to `div_i` during a period applies from the next period, and the current period keeps its length.
- R6: With `bypass_i`=1, `launch_o` is high on every fast cycle of the burst (`cpl_i`+1 cycles, from the cycle after edge k). `pclk_o` follows the fast clock during the burst and is 0 outside it.
- R7: With `tft_i`=0, `bias_o` toggles on every (`acb_i`+1)-th line strobe and changes at no other time.
- R8: With `tft_i`=1, `bias_o` equals `de_i` when `inv_de_i`=0 and its inverse when `inv_de_i`=1. Line strobes and `acb_i` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W (5) | Divisor; ratio is div_i+2 |
| bypass_i | input | 1 | 1 = skip the divider, panel at fast rate |
| inv_clk_i | input | 1 | 0 = launch at rising panel edge, 1 = falling |
| inv_de_i | input | 1 | Data-enable polarity in active-matrix mode (1 = active low) |
| tft_i | input | 1 | 1 = active-matrix mode, 0 = passive-matrix mode |
| acb_i | input | ACB_W (5) | Line strobes between bias toggles, minus one |
| cpl_i | input | CPL_W (10) | Panel clocks per line, minus one |
| line_strobe_i | input | 1 | One-cycle line start pulse |
| de_i | input | 1 | Data valid from the timing logic |
| pclk_o | output | 1 | Panel clock |
| launch_o | output | 1 | One-cycle data launch enable |
| bias_o | output | 1 | AC bias or data-enable pin |

## Verification
The assertions assume that `bypass_i` and `inv_clk_i` change only while no burst is running. Under this assumption the launch edge and the strobe spacing are well defined in each cycle. They also assume `tft_i` is held for at least a cycle around the bias checks. The bench changes these controls only at a falling edge, after the previous burst has fully drained. Within a burst it changes only `div_i`, to exercise the wrap-time sampling.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/pcg_divider.sv
module pcg_divider
    import pcg_pkg::*;
#(
    parameter int DIV_W = 5,
    parameter int CPL_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             bypass_i,
    input  logic             inv_clk_i,
    input  logic [CPL_W-1:0] cpl_i,
    input  logic             line_strobe_i,
    output logic             pclk_o,
    output logic             launch_o,
    output logic             busy_o
);
    localparam int RAT_W = DIV_W + 1;
    localparam int REM_W = CPL_W + 1;

    phase_e           state_q, state_d;
    logic [RAT_W-1:0] cnt_q, cnt_d;
    logic [RAT_W-1:0] ratio_q, ratio_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic             first_q, first_d;
    logic [RAT_W-1:0] new_ratio;
    logic             owed;

    assign new_ratio = RAT_W'(div_i) + RAT_W'(2);
    assign owed      = (rem_q != '0);

    // Periods still owed on this line
    always_comb begin
        if (line_strobe_i)
            rem_d = REM_W'(cpl_i) + REM_W'(1);
        else if (bypass_i)
            rem_d = owed ? rem_q - REM_W'(1) : rem_q;
        else if (state_q == PH_LOW && cnt_q == '0)
            rem_d = rem_q - REM_W'(1);
        else
            rem_d = rem_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        first_d = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (!bypass_i && owed) begin
                    state_d = PH_HIGH;
                    ratio_d = new_ratio;
                    cnt_d   = (new_ratio >> 1) - RAT_W'(1);
                    first_d = 1'b1;
                end
            end
            PH_HIGH: begin
                if (cnt_q == '0) begin
                    state_d = PH_LOW;
                    cnt_d   = ratio_q - (ratio_q >> 1) - RAT_W'(1);
                    first_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - RAT_W'(1);
                end
            end
            PH_LOW: begin
                if (cnt_q == '0) begin
                    if (!bypass_i && rem_d != '0) begin
                        state_d = PH_HIGH;
                        ratio_d = new_ratio;
                        cnt_d   = (new_ratio >> 1) - RAT_W'(1);
                        first_d = 1'b1;
                    end else begin
                        state_d = PH_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - RAT_W'(1);
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            ratio_q <= RAT_W'(2);
            rem_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
            rem_q   <= rem_d;
            first_q <= first_d;
        end
    end

    // Outputs
    always_comb begin
        pclk_o = (state_q == PH_HIGH);
        busy_o = owed;
        if (bypass_i)
            launch_o = owed;
        else if (inv_clk_i)
            launch_o = first_q && (state_q == PH_LOW);
        else
            launch_o = first_q && (state_q == PH_HIGH);
    end
endmodule

// File: rtl/pcg_bias.sv
module pcg_bias #(
    parameter int ACB_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tft_i,
    input  logic             inv_de_i,
    input  logic             de_i,
    input  logic [ACB_W-1:0] acb_i,
    input  logic             line_strobe_i,
    output logic             bias_o
);
    logic [ACB_W-1:0] lcnt_q;
    logic             ac_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lcnt_q <= '0;
            ac_q   <= 1'b0;
        end else if (!tft_i && line_strobe_i) begin
            if (lcnt_q >= acb_i) begin
                lcnt_q <= '0;
                ac_q   <= ~ac_q;
            end else begin
                lcnt_q <= lcnt_q + ACB_W'(1);
            end
        end
    end

    assign bias_o = tft_i ? (de_i ^ inv_de_i) : ac_q;
endmodule

// File: rtl/pnl_clkgen.sv
module pnl_clkgen #(
    parameter int DIV_W = 5,
    parameter int CPL_W = 10,
    parameter int ACB_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             bypass_i,
    input  logic             inv_clk_i,
    input  logic             inv_de_i,
    input  logic             tft_i,
    input  logic [ACB_W-1:0] acb_i,
    input  logic [CPL_W-1:0] cpl_i,
    input  logic             line_strobe_i,
    input  logic             de_i,
    output logic             pclk_o,
    output logic             launch_o,
    output logic             bias_o
);
    logic pclk_div;
    logic busy;
    logic gate_q;

    pcg_divider #(.DIV_W(DIV_W), .CPL_W(CPL_W)) u_div (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .div_i         (div_i),
        .bypass_i      (bypass_i),
        .inv_clk_i     (inv_clk_i),
        .cpl_i         (cpl_i),
        .line_strobe_i (line_strobe_i),
        .pclk_o        (pclk_div),
        .launch_o      (launch_o),
        .busy_o        (busy)
    );

    pcg_bias #(.ACB_W(ACB_W)) u_bias (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tft_i         (tft_i),
        .inv_de_i      (inv_de_i),
        .de_i          (de_i),
        .acb_i         (acb_i),
        .line_strobe_i (line_strobe_i),
        .bias_o        (bias_o)
    );

    // Gate enable for bypass: captured while the fast clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= busy;
    end

    assign pclk_o = bypass_i ? (clk_i & gate_q) : pclk_div;
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
    parameter int DIV_W = 5
) (
    input logic clk_i,
    input logic rst_ni,
    input logic bypass_i,
    input logic inv_clk_i,
    input logic tft_i,
    input logic line_strobe_i,
    input logic pclk_o,
    input logic launch_o,
    input logic bias_o
);
    localparam int HI_MAX = ((1 << DIV_W) + 1) / 2;
    logic [DIV_W:0] hrun_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  hrun_q <= '0;
        else if (!bypass_i && pclk_o) hrun_q <= hrun_q + 1'b1;
        else                          hrun_q <= '0;
    end

    // R3: high phase never longer than half the largest ratio
    a_r3_high_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && pclk_o) |-> (hrun_q < (DIV_W+1)'(HI_MAX)));

    // R4: divided-mode launch strobe is a single cycle
    a_r4_single_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && launch_o) |=> (bypass_i || !launch_o));

    // R4: launch at the rising edge sits in the high phase
    a_r4_rise_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && !inv_clk_i && launch_o) |-> pclk_o);

    // R4: launch at the falling edge sits in the low phase
    a_r4_fall_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && inv_clk_i && launch_o) |-> !pclk_o);

    // R7: passive-mode bias only moves on a line strobe
    a_r7_bias_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tft_i && !line_strobe_i) |=> (tft_i || $stable(bias_o)));
endmodule

bind pnl_clkgen pcg_checker #(.DIV_W(DIV_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bypass_i      (bypass_i),
    .inv_clk_i     (inv_clk_i),
    .tft_i         (tft_i),
    .line_strobe_i (line_strobe_i),
    .pclk_o        (pclk_o),
    .launch_o      (launch_o),
    .bias_o        (bias_o)
);

// File: tb/pnl_clkgen_tb.sv
module pnl_clkgen_tb;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [4:0] div_i = '0;
    logic       bypass_i = 1'b0;
    logic       inv_clk_i = 1'b0;
    logic       inv_de_i = 1'b0;
    logic       tft_i = 1'b0;
    logic [4:0] acb_i = '0;
    logic [9:0] cpl_i = '0;
    logic       line_strobe_i = 1'b0;
    logic       de_i = 1'b0;
    logic       pclk_o, launch_o, bias_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk_i = ~clk_i;  // 125 MHz

    pnl_clkgen u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .bypass_i(bypass_i),
        .inv_clk_i(inv_clk_i), .inv_de_i(inv_de_i), .tft_i(tft_i),
        .acb_i(acb_i), .cpl_i(cpl_i), .line_strobe_i(line_strobe_i),
        .de_i(de_i), .pclk_o(pclk_o), .launch_o(launch_o), .bias_o(bias_o)
    );

    task automatic check(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %0b expected %0b", req, $time, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        check("R1 pclk", pclk_o, 1'b0);
        check("R1 launch", launch_o, 1'b0);
        check("R1 bias", bias_o, 1'b0);
        repeat (3) @(negedge clk_i);
        check("R1 pclk idle", pclk_o, 1'b0);
    endtask

    // R2 R3 R4 R5: divided burst; first period uses d1, later ones d2
    task automatic t_burst(int d1, int d2, int cpl, bit inv);
        int n1 = d1 + 2;
        int n2 = d2 + 2;
        int periods = cpl + 1;
        int span = n1 + (periods - 1) * n2;
        inv_clk_i = inv;
        div_i = 5'(d1);
        cpl_i = 10'(cpl);
        line_strobe_i = 1'b1;
        @(negedge clk_i);
        line_strobe_i = 1'b0;
        for (int m = 0; m < span + 4; m++) begin
            int ph = -1;
            int n = n1;
            logic ep, el;
            if (m >= 1) begin
                int pos = m - 1;
                if (pos < n1) ph = pos;
                else if (pos - n1 < (periods - 1) * n2) begin
                    ph = (pos - n1) % n2;
                    n = n2;
                end
            end
            ep = (ph >= 0) && (ph < n / 2);
            el = (ph >= 0) && (ph == (inv ? n / 2 : 0));
            check("R2/R3/R5 pclk", pclk_o, ep);
            check("R4 launch", launch_o, el);
            if (m == 1) div_i = 5'(d2);
            @(negedge clk_i);
        end
    endtask

    // R6: bypass mode
    task automatic t_bypass(int cpl);
        bypass_i = 1'b1;
        cpl_i = 10'(cpl);
        @(negedge clk_i);
        line_strobe_i = 1'b1;
        @(negedge clk_i);
        line_strobe_i = 1'b0;
        for (int m = 0; m < cpl + 4; m++) begin
            check("R6 launch", launch_o, (m <= cpl));
            check("R6 pclk low phase", pclk_o, 1'b0);
            @(negedge clk_i);
        end
        line_strobe_i = 1'b1;
        @(negedge clk_i);
        line_strobe_i = 1'b0;
        @(posedge clk_i);
        #2;
        check("R6 pclk follows clock", pclk_o, 1'b1);
        repeat (cpl + 4) @(negedge clk_i);
        @(posedge clk_i);
        #2;
        check("R6 pclk after burst", pclk_o, 1'b0);
        @(negedge clk_i);
        bypass_i = 1'b0;
        @(negedge clk_i);
    endtask

    // R7: passive bias toggling
    task automatic t_stn_bias(int acb, int count);
        logic exp = 1'b0;
        do_reset();
        tft_i = 1'b0;
        acb_i = 5'(acb);
        cpl_i = '0;
        for (int s = 1; s <= count; s++) begin
            line_strobe_i = 1'b1;
            @(negedge clk_i);
            line_strobe_i = 1'b0;
            if (s % (acb + 1) == 0) exp = ~exp;
            check("R7 bias after strobe", bias_o, exp);
            repeat (2) @(negedge clk_i);
            check("R7 bias between strobes", bias_o, exp);
        end
    endtask

    // R8: active-matrix data enable
    task automatic t_tft();
        do_reset();
        tft_i = 1'b1;
        for (int c = 0; c < 4; c++) begin
            de_i = c[0];
            inv_de_i = c[1];
            @(negedge clk_i);
            check("R8 de polarity", bias_o, c[0] ^ c[1]);
        end
        de_i = 1'b0;
        inv_de_i = 1'b0;
        acb_i = '0;
        for (int s = 0; s < 3; s++) begin
            line_strobe_i = 1'b1;
            @(negedge clk_i);
            line_strobe_i = 1'b0;
            check("R8 strobe ignored", bias_o, 1'b0);
            @(negedge clk_i);
        end
        tft_i = 1'b0;
        @(negedge clk_i);
        check("R8 counter frozen in tft", bias_o, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_burst(0, 0, 2, 1'b0);
        t_burst(3, 3, 3, 1'b0);
        t_burst(3, 3, 2, 1'b1);
        t_burst(31, 31, 1, 1'b0);
        t_burst(0, 2, 3, 1'b0);
        t_burst(4, 1, 2, 1'b1);
        t_bypass(5);
        t_burst(1, 1, 1, 1'b0);
        t_stn_bias(2, 7);
        t_stn_bias(0, 4);
        t_tft();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule